// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small synchronous credit machine for a single-slot coin acceptor. An external coin sensor raises one of two one-cycle pulses, one for a 5-cent coin and one for a 10-cent coin. The controller adds up the credit and moves to a paid state once at least 15 cents have been inserted. Anything paid above the price is kept. No change is returned, and the paid state is left only through reset.

The credit is held in four states: 0, 5, 10 and "15 or more" cents. Two release outputs drive the dispensing mechanism, and both are provided so their timing can be compared. The state-based (Moore) release comes straight from the register and rises on the clock edge after the qualifying coin. The transition-based (Mealy) release also looks at the coin now being presented. It therefore rises in the same cycle as the qualifying coin, one cycle ahead of the Moore release.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While `rst_i` is high, `release_mealy_o` is low. After a clock edge with `rst_i` high, the credit is 0 cents and `release_moore_o` is low. Reset takes priority over any coin pulse.
- R2: A `nickel_i` pulse alone adds 5 cents: 0 goes to 5, 5 goes to 10, and 10 goes to paid.
- R3: A `dime_i` pulse alone adds 10 cents: 0 goes to 10, and both 5 and 10 go to paid. The excess is not refunded.
- R4: A cycle with neither pulse leaves the credit unchanged.
- R5: A cycle with `nickel_i` and `dime_i` both high counts as no coin and leaves the credit unchanged.
- R6: Once in the paid state, the machine stays there for any coin input until reset.
- R7: `release_moore_o` is high exactly while the registered credit is in the paid state, so it rises on the clock edge after the qualifying coin.
- R8: Outside reset, `release_mealy_o` is high when the credit is already paid, or when the coin now presented brings it to 15 cents or more. It is low otherwise.
- R9: The credit states are encoded as 0 cents = 2'b00, 5 = 2'b01, 10 = 2'b10 and paid = 2'b11, so the reset state is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was inserted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was inserted |
| release_moore_o | output | 1 | Release decoded from the registered state |
| release_mealy_o | output | 1 | Release decoded from state and the present coin |

## Verification
The bench targets several corner cases:
- A dime on 10 cents. A design that does not saturate would wrap the credit back to a low state.
- Both pulses in one cycle. A wrong design would add one of the coins.
- Coins and an idle input after payment. A wrong design would leave or re-enter the paid state.
- A coin asserted together with reset. A design that lets the coin win would come out of reset with credit.

The bench also checks that the Mealy release rises one cycle ahead of the Moore release on each qualifying coin. A design that registered the Mealy output, or decoded the Moore output from the next state, would make both rise together. A pseudo-random coin stream is checked against a counter that saturates at 15 cents.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STATE_W      = 2;
    localparam int NICKEL_CENTS = 5;
    localparam int DIME_CENTS   = 10;
    localparam int PRICE_CENTS  = 15;

    // R9: credit encoding, reset state all zeros
    typedef enum logic [STATE_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_PAID = 2'b11
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10
    } coin_e;

    typedef struct packed {
        credit_e credit;
    } ctrl_state_t;

    function automatic int cents_of(credit_e c);
        case (c)
            CR_ZERO: return 0;
            CR_FIVE: return NICKEL_CENTS;
            CR_TEN:  return 2 * NICKEL_CENTS;
            default: return PRICE_CENTS;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    // R5: simultaneous pulses are treated as no coin
    always_comb begin
        case ({dime_i, nickel_i})
            2'b01:   coin_o = COIN_NICKEL;
            2'b10:   coin_o = COIN_DIME;
            default: coin_o = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
    import vend_pkg::*;
(
    input  credit_e credit_i,
    input  coin_e   coin_i,
    output credit_e credit_nx_o
);
    always_comb begin
        credit_nx_o = credit_i;
        case (credit_i)
            CR_ZERO: begin
                if (coin_i == COIN_NICKEL)    credit_nx_o = CR_FIVE;
                else if (coin_i == COIN_DIME) credit_nx_o = CR_TEN;
            end
            CR_FIVE: begin
                if (coin_i == COIN_NICKEL)    credit_nx_o = CR_TEN;
                else if (coin_i == COIN_DIME) credit_nx_o = CR_PAID;
            end
            CR_TEN: begin
                if (coin_i != COIN_NONE)      credit_nx_o = CR_PAID;
            end
            default: credit_nx_o = CR_PAID;
        endcase
    end
endmodule

// File: rtl/vend_release_out.sv
module vend_release_out
    import vend_pkg::*;
(
    input  logic    rst_i,
    input  credit_e credit_i,
    input  credit_e credit_nx_i,
    output logic    moore_o,
    output logic    mealy_o
);
    always_comb begin
        moore_o = (credit_i == CR_PAID);
        mealy_o = !rst_i && ((credit_i == CR_PAID) || (credit_nx_i == CR_PAID));
    end
endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
    import vend_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic nickel_i,
    input  logic dime_i,
    output logic release_moore_o,
    output logic release_mealy_o
);
    coin_e       coin;
    credit_e     credit_nx;
    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic [STATE_W-1:0] credit_q_w;

    vend_coin_decode u_dec (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_credit_next u_next (
        .credit_i    (st_q.credit),
        .coin_i      (coin),
        .credit_nx_o (credit_nx)
    );

    vend_release_out u_out (
        .rst_i       (rst_i),
        .credit_i    (st_q.credit),
        .credit_nx_i (credit_nx),
        .moore_o     (release_moore_o),
        .mealy_o     (release_mealy_o)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) st_d.credit = CR_ZERO;
        else       st_d.credit = credit_nx;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign credit_q_w = st_q.credit;

endmodule

// File: rtl/vend_credit_ctrl_chk.sv
module vend_credit_ctrl_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       nickel_i,
    input logic       dime_i,
    input logic [1:0] credit_q,
    input logic       release_moore_o,
    input logic       release_mealy_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (credit_q == 2'b00 && !release_moore_o));

    // R1
    mealy_reset_low_chk: assert property (@(posedge clk_i)
        rst_i |-> !release_mealy_o);

    // R4
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!nickel_i && !dime_i) |=> $stable(credit_q));

    // R5
    dual_coin_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (nickel_i && dime_i) |=> $stable(credit_q));

    // R2
    nickel_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (credit_q == 2'b00 && nickel_i && !dime_i) |=> (credit_q == 2'b01));

    // R3
    dime_saturate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (credit_q == 2'b10 && dime_i && !nickel_i) |=> (credit_q == 2'b11));

    // R6
    paid_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        release_moore_o |=> release_moore_o);

    // R7
    moore_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(release_moore_o) |-> $past(release_mealy_o));

    // R8
    mealy_lead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (release_mealy_o && !release_moore_o) |=> release_moore_o);

    // R8
    mealy_covers_moore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        release_moore_o |-> release_mealy_o);
endmodule

bind vend_credit_ctrl vend_credit_ctrl_chk u_chk (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .nickel_i        (nickel_i),
    .dime_i          (dime_i),
    .credit_q        (credit_q_w),
    .release_moore_o (release_moore_o),
    .release_mealy_o (release_mealy_o)
);

// File: tb/vend_credit_ctrl_bench.sv
module vend_credit_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic moore;
    logic mealy;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vend_credit_ctrl u_vend_credit_ctrl (
        .clk_i           (clk),
        .rst_i           (rst),
        .nickel_i        (nickel),
        .dime_i          (dime),
        .release_moore_o (moore),
        .release_mealy_o (mealy)
    );

    // {req, rst, nickel, dime, exp_mealy (same cycle), exp_moore (after edge)}
    localparam int NV = 23;
    localparam logic [8:0] VEC [NV] = '{
        {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd8, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {4'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
        {4'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    function automatic string req_name(int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check Mealy before the edge, Moore after it
    task automatic step(logic r, logic n, logic d, string req, logic em, logic eo);
        @(negedge clk);
        rst = r; nickel = n; dime = d;
        #2;
        check(req, "mealy", mealy, em);
        @(posedge clk);
        #2;
        check(req, "moore", moore, eo);
    endtask

    initial begin
        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][4], VEC[i][3], VEC[i][2], req_name(int'(VEC[i][8:5])),
                 VEC[i][1], VEC[i][0]);
        end

        // R1 directed: after reset both outputs idle, R9 reset credit is zero
        @(negedge clk); rst = 1'b0; nickel = 1'b0; dime = 1'b0; #2;
        check("R1", "mealy idle after reset", mealy, 1'b0);
        check("R9", "moore idle at zero credit", moore, 1'b0);

        // R6 directed: reach paid, then many mixed coins keep it
        step(1'b0, 1'b0, 1'b1, "R3", 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, "R2", 1'b1, 1'b1);
        for (int k = 0; k < 8; k++) begin
            step(1'b0, k[0], k[1], "R6", 1'b1, 1'b1);
        end
        // R7 directed: Moore still high until the reset edge
        @(negedge clk); rst = 1'b1; nickel = 1'b0; dime = 1'b0; #2;
        check("R7", "moore before reset edge", moore, 1'b1);
        check("R1", "mealy in reset cycle", mealy, 1'b0);
        @(posedge clk); #2;
        check("R1", "moore after reset edge", moore, 1'b0);

        // pseudo-random stream against a saturating cents counter
        begin
            logic [7:0] lfsr = 8'hA5;
            int credit = 0;
            for (int c = 0; c < 150; c++) begin
                logic r, n, d, em, eo;
                int nxt;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                r = (lfsr[7:5] == 3'b111) && lfsr[2];
                n = lfsr[0];
                d = lfsr[1];
                nxt = credit;
                if (n && !d) nxt = credit + 5;
                if (d && !n) nxt = credit + 10;
                if (nxt > 15) nxt = 15;
                em = !r && (nxt >= 15);
                if (r) nxt = 0;
                eo = (nxt >= 15);
                step(r, n, d, "R8", em, eo);
                credit = nxt;
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule